// File: doc/BRIEF.md
# Serial Transmitter with Clear-to-Send Gating and Automatic Request-to-Send Release

This block turns bytes into asynchronous serial frames on a single output line. A small first-in first-out queue feeds it. All timing comes from a strobe supplied at sixteen times the bit rate. A frame is a low start bit, eight data bits sent least significant bit first, an optional even parity bit and a stop period. The stop period is set in sixteenths of a bit. A one-strobe-per-bit mode is also available, and in that mode the stop period is one or two whole bits.

Two flow-control features are built in. The first lets an active-low clear-to-send input hold back each new character. The input is checked only when a character is about to begin, so a character already on the line always completes. The second is an end-of-message mode. When the transmitter has been disabled, the active-low request-to-send output is released one bit time after the queue and the shift path have fully drained. Without that mode, request-to-send follows explicit commands only. Software first selects the mode, enables the transmitter and asserts request-to-send. It then writes the message and disables the transmitter after the last byte. Bytes already queued are still sent.

Top module: `uart_tx_flow`

## Requirements
- R1: Each frame is a start bit at 0, then 8 data bits least significant bit first, each bit lasting 16 strobes. The line idles at 1 and changes only in the clock cycle that follows a strobe.
- R2: When mode bit 6 is 1, one even parity bit (the XOR of the 8 data bits) is sent between the last data bit and the stop period.
- R3: In 16x mode, mode bits [3:0] set the stop length. Code c from 0 to 7 gives 9+c strobes, and code c from 8 to 15 gives 17+c strobes. Back-to-back frames therefore start exactly (9 + parity) x 16 + stop strobes apart.
- R4: When mode bit 7 is 1, each bit lasts one strobe, and mode bit 0 selects one (0) or two (1) stop bits.
- R5: When mode bit 4 is 1 and ctsn is high (after a two-cycle synchronizer) at the moment a character could start, the line stays at 1 and the character waits. It starts on the first strobe after ctsn is seen low.
- R6: A change on ctsn while a character is on the line does not alter that character.
- R7: When mode bit 4 is 0, ctsn has no effect on transmission.
- R8: tx_ready is 1 exactly when the transmitter is enabled and the queue is not full, and fifo_full is 1 when the queue holds 8 bytes. A write while tx_ready is 0 is dropped.
- R9: A disable command discards nothing. Bytes already queued are still sent in full.
- R10: cmd_rts_on drives rtsn to 0 and cmd_rts_off drives it to 1 in the next cycle. With mode bit 5 at 0, draining the queue leaves rtsn unchanged.
- R11: With mode bit 5 at 1 and the transmitter disabled, rtsn goes to 1 on the bit-time-th strobe (16, or 1 in 1x mode) after the strobe that ends the last stop period. While the transmitter is enabled, no automatic release happens.
- R12: After reset, txd and rtsn are 1, tx_ready and fifo_full are 0, and the mode is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_16x | input | 1 | One-cycle strobe at sixteen times the bit rate |
| wr_en | input | 1 | Write strobe for the transmit queue |
| wr_data | input | 8 | Byte to queue |
| fifo_full | output | 1 | Queue holds its full depth |
| tx_ready | output | 1 | Enabled and queue has room |
| cmd_tx_on | input | 1 | Enable command pulse |
| cmd_tx_off | input | 1 | Disable command pulse |
| cmd_rts_on | input | 1 | Drive rtsn low, command pulse |
| cmd_rts_off | input | 1 | Drive rtsn high, command pulse |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | [3:0] stop code, [4] clear-to-send gating, [5] automatic release, [6] parity, [7] 1x mode |
| ctsn | input | 1 | Active-low clear-to-send |
| rtsn | output | 1 | Active-low request-to-send |
| txd | output | 1 | Serial output |

## Verification
Several properties are checked on every cycle. The line moves only after a strobe. rtsn falls only after an assert command, and it rises on its own only on a strobe with the line drained, the end-of-message mode set and the transmitter disabled. A gated, idle line with clear-to-send high stays idle. tx_ready is never high with a full queue, and a full queue stays full until a character is taken. Only the bench scenarios can show the exact frame contents, the spacing of back-to-back frames for each stop code, the strobe on which rtsn is released, and that a character cut across by a clear-to-send change still arrives whole.

// File: rtl/uart_tx_flow_pkg.sv
package uart_tx_flow_pkg;

  // Phase of the serial frame currently on the line
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } phase_t;

  // Mode register layout, most significant field first
  typedef struct packed {
    logic       one_x;      // [7] one strobe per bit
    logic       par_en;     // [6] even parity bit
    logic       auto_rts;   // [5] release rtsn after drain
    logic       cts_gate;   // [4] gate starts on ctsn
    logic [3:0] stop_code;  // [3:0] stop length code
  } mode_t;

  localparam int TICKS_PER_BIT = 16;
  localparam int TW            = $clog2(2 * TICKS_PER_BIT) + 1;  // holds up to 32
  localparam int GW            = $clog2(TICKS_PER_BIT) + 1;      // holds up to 16

  function automatic logic [TW-1:0] bit_ticks(input mode_t m);
    if (m.one_x) return TW'(1);
    return TW'(TICKS_PER_BIT);
  endfunction

  // Stop period in strobes: 9..16 for codes 0..7, 25..32 for codes 8..15
  function automatic logic [TW-1:0] stop_ticks(input mode_t m);
    if (m.one_x)
      return m.stop_code[0] ? TW'(2) : TW'(1);
    if (!m.stop_code[3])
      return TW'(9) + TW'(m.stop_code[2:0]);
    return TW'(25) + TW'(m.stop_code[2:0]);
  endfunction

endpackage

// File: rtl/uart_tx_fifo.sv
module uart_tx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         full,
  output logic         empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_ok)
      wr_ptr_d = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    if (pop_ok)
      rd_ptr_d = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    unique case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // Storage carries no reset; the count guards every read
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= wdata;
  end

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer
  import uart_tx_flow_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  mode_t             mode,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic              cts_ok,
  output logic              fifo_pop,
  output logic              txd,
  output logic              line_idle
);

  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  phase_t            phase_q, phase_d;
  logic [TW-1:0]     cnt_q, cnt_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;

  logic [TW-1:0]     bt, sl, cnt_inc;
  logic              bit_end, stop_end, can_start, do_load;

  assign bt        = bit_ticks(mode);
  assign sl        = stop_ticks(mode);
  assign cnt_inc   = cnt_q + 1'b1;
  assign bit_end   = (cnt_inc == bt);
  assign stop_end  = (cnt_inc == sl);
  // Flow control is consulted only here, at a character boundary
  assign can_start = !fifo_empty && cts_ok;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    par_d   = par_q;
    do_load = 1'b0;
    if (tick) begin
      unique case (phase_q)
        PH_IDLE: begin
          if (can_start) do_load = 1'b1;
        end
        PH_START: begin
          if (bit_end) begin
            phase_d = PH_DATA;
            cnt_d   = '0;
            idx_d   = '0;
          end else begin
            cnt_d = cnt_inc;
          end
        end
        PH_DATA: begin
          if (bit_end) begin
            cnt_d = '0;
            if (idx_q == IW'(DATA_W - 1)) begin
              phase_d = mode.par_en ? PH_PAR : PH_STOP;
            end else begin
              idx_d = idx_q + 1'b1;
              sh_d  = sh_q >> 1;
            end
          end else begin
            cnt_d = cnt_inc;
          end
        end
        PH_PAR: begin
          if (bit_end) begin
            phase_d = PH_STOP;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_inc;
          end
        end
        PH_STOP: begin
          if (stop_end) begin
            if (can_start) begin
              do_load = 1'b1;
            end else begin
              phase_d = PH_IDLE;
              cnt_d   = '0;
            end
          end else begin
            cnt_d = cnt_inc;
          end
        end
        default: phase_d = PH_IDLE;
      endcase
    end
    if (do_load) begin
      phase_d = PH_START;
      cnt_d   = '0;
      idx_d   = '0;
      sh_d    = fifo_data;
      par_d   = ^fifo_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      par_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      par_q   <= par_d;
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_START: txd = 1'b0;
      PH_DATA:  txd = sh_q[0];
      PH_PAR:   txd = par_q;
      default:  txd = 1'b1;
    endcase
  end

  assign fifo_pop  = do_load;
  assign line_idle = (phase_q == PH_IDLE);

endmodule

// File: rtl/uart_tx_rts_ctrl.sv
module uart_tx_rts_ctrl
  import uart_tx_flow_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  mode_t mode,
  input  logic  tx_enabled,
  input  logic  drained,
  input  logic  rts_on,
  input  logic  rts_off,
  output logic  rtsn
);

  logic [GW-1:0] gcnt_q, gcnt_d;
  logic [GW-1:0] bt_g;
  logic          rtsn_q, rtsn_d;
  logic          release_now;

  assign bt_g = GW'(bit_ticks(mode));

  // Guard counter: strobes seen since the line and queue became empty.
  // It saturates at one bit time, so the release is a single event.
  always_comb begin
    gcnt_d = gcnt_q;
    if (!drained)
      gcnt_d = '0;
    else if (tick && (gcnt_q < bt_g))
      gcnt_d = gcnt_q + 1'b1;
  end

  assign release_now = drained && tick && (gcnt_q == bt_g - 1'b1) &&
                       mode.auto_rts && !tx_enabled;

  always_comb begin
    rtsn_d = rtsn_q;
    if (rts_on)
      rtsn_d = 1'b0;
    else if (rts_off || release_now)
      rtsn_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcnt_q <= '0;
      rtsn_q <= 1'b1;
    end else begin
      gcnt_q <= gcnt_d;
      rtsn_q <= rtsn_d;
    end
  end

  assign rtsn = rtsn_q;

endmodule

// File: rtl/uart_tx_flow.sv
module uart_tx_flow
  import uart_tx_flow_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_16x,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              fifo_full,
  output logic              tx_ready,
  input  logic              cmd_tx_on,
  input  logic              cmd_tx_off,
  input  logic              cmd_rts_on,
  input  logic              cmd_rts_off,
  input  logic              mode_we,
  input  logic [7:0]        mode_wdata,
  input  logic              ctsn,
  output logic              rtsn,
  output logic              txd
);

  logic              rst_s1, rst_n_sync;
  logic              enabled_q, enabled_d;
  mode_t             mode_q, mode_d;
  logic              cts_s1, cts_s2;
  logic              cts_ok;
  logic              push;
  logic              fifo_pop, fifo_empty;
  logic [DATA_W-1:0] fifo_rdata;
  logic              line_idle;

  // Reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_s1     <= 1'b1;
      rst_n_sync <= rst_s1;
    end
  end

  always_comb begin
    enabled_d = enabled_q;
    if (cmd_tx_off)
      enabled_d = 1'b0;
    else if (cmd_tx_on)
      enabled_d = 1'b1;
    mode_d = mode_we ? mode_t'(mode_wdata) : mode_q;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      enabled_q <= 1'b0;
      mode_q    <= '0;
      cts_s1    <= 1'b1;
      cts_s2    <= 1'b1;
    end else begin
      enabled_q <= enabled_d;
      mode_q    <= mode_d;
      cts_s1    <= ctsn;
      cts_s2    <= cts_s1;
    end
  end

  assign cts_ok   = !mode_q.cts_gate || !cts_s2;
  assign tx_ready = enabled_q && !fifo_full;
  assign push     = wr_en && tx_ready;

  uart_tx_fifo #(
    .W     (DATA_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .push  (push),
    .wdata (wr_data),
    .pop   (fifo_pop),
    .rdata (fifo_rdata),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  uart_tx_serializer #(
    .DATA_W (DATA_W)
  ) u_ser (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .tick       (tick_16x),
    .mode       (mode_q),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_rdata),
    .cts_ok     (cts_ok),
    .fifo_pop   (fifo_pop),
    .txd        (txd),
    .line_idle  (line_idle)
  );

  uart_tx_rts_ctrl u_rts (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .tick       (tick_16x),
    .mode       (mode_q),
    .tx_enabled (enabled_q),
    .drained    (line_idle && fifo_empty),
    .rts_on     (cmd_rts_on),
    .rts_off    (cmd_rts_off),
    .rtsn       (rtsn)
  );

endmodule

// File: rtl/uart_tx_flow_chk.sv
module uart_tx_flow_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic txd,
  input logic rtsn,
  input logic fifo_full,
  input logic tx_ready,
  input logic cmd_rts_on,
  input logic cmd_rts_off,
  input logic line_idle,
  input logic fifo_empty,
  input logic fifo_pop,
  input logic tx_enabled,
  input logic auto_rts,
  input logic cts_gate,
  input logic ctsn_s
);

  // R1
  txd_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(txd));

  // R10
  rtsn_fall_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rtsn) |-> $past(cmd_rts_on));

  // R11
  auto_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rtsn) && !$past(cmd_rts_off)) |->
      $past(tick && line_idle && fifo_empty && auto_rts && !tx_enabled));

  // R5
  cts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_idle && cts_gate && ctsn_s) |=> line_idle);

  // R8
  ready_not_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !fifo_full);

  // R8
  full_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !fifo_pop) |=> fifo_full);

endmodule

bind uart_tx_flow uart_tx_flow_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .tick        (tick_16x),
  .txd         (txd),
  .rtsn        (rtsn),
  .fifo_full   (fifo_full),
  .tx_ready    (tx_ready),
  .cmd_rts_on  (cmd_rts_on),
  .cmd_rts_off (cmd_rts_off),
  .line_idle   (line_idle),
  .fifo_empty  (fifo_empty),
  .fifo_pop    (fifo_pop),
  .tx_enabled  (enabled_q),
  .auto_rts    (mode_q.auto_rts),
  .cts_gate    (mode_q.cts_gate),
  .ctsn_s      (cts_s2)
);

// File: tb/uart_tx_flow_tb.sv
module uart_tx_flow_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 3;
  localparam int DEPTH      = 8;
  localparam int WATCHDOG   = 180000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_16x = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       fifo_full, tx_ready, rtsn, txd;
  logic       cmd_tx_on = 1'b0, cmd_tx_off = 1'b0;
  logic       cmd_rts_on = 1'b0, cmd_rts_off = 1'b0;
  logic       mode_we = 1'b0;
  logic [7:0] mode_wdata = 8'h00;
  logic       ctsn = 1'b0;

  uart_tx_flow u_dut (
    .clk(clk), .rst_n(rst_n), .tick_16x(tick_16x),
    .wr_en(wr_en), .wr_data(wr_data), .fifo_full(fifo_full), .tx_ready(tx_ready),
    .cmd_tx_on(cmd_tx_on), .cmd_tx_off(cmd_tx_off),
    .cmd_rts_on(cmd_rts_on), .cmd_rts_off(cmd_rts_off),
    .mode_we(mode_we), .mode_wdata(mode_wdata),
    .ctsn(ctsn), .rtsn(rtsn), .txd(txd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int tdiv = 0;
  always @(negedge clk) begin
    tick_16x <= (tdiv == 0);
    tdiv = (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
  end

  int tcount = 0;
  always @(posedge clk) if (tick_16x) tcount <= tcount + 1;

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string req, input longint act,
                     input longint expv, input string what);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Model of the requirements
  int cur_par = 0, cur_x1 = 0, cur_L = 9;
  function automatic int exp_stop(input int code, input int x1);
    if (x1 != 0) return (code % 2 == 1) ? 2 : 1;
    if (code < 8) return 9 + code;
    return 17 + code;
  endfunction
  function automatic int exp_bt(input int x1);
    return (x1 != 0) ? 1 : 16;
  endfunction
  function automatic int exp_frame(input int par, input int x1, input int code);
    return (9 + par) * exp_bt(x1) + exp_stop(code, x1);
  endfunction

  task automatic wait_t(input int target);
    while (tcount < target) @(negedge clk);
  endtask
  task automatic wait_ticks(input int n);
    int t;
    t = tcount;
    while (tcount < t + n) @(negedge clk);
  endtask

  // Line monitor
  logic [7:0] rx_q[$];
  logic [7:0] exp_q[$];
  int t0_q[$];
  int ts_q[$];
  int rx_cnt = 0;
  logic mon_prev = 1'b1;
  int m_t0, m_bt, m_ts;
  logic [7:0] m_b;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && txd === 1'b0 && mon_prev) begin
        m_t0 = tcount;
        m_bt = exp_bt(cur_x1);
        wait_t(m_t0 + m_bt / 2);
        chk(txd === 1'b0, "R1", txd, 0, "start bit level");
        for (int k = 1; k <= 8; k++) begin
          wait_t(m_t0 + k * m_bt + m_bt / 2);
          m_b[k-1] = txd;
        end
        if (cur_par != 0) begin
          wait_t(m_t0 + 9 * m_bt + m_bt / 2);
          chk(txd === ^m_b, "R2", txd, ^m_b, "even parity bit");
        end
        m_ts = m_t0 + (9 + cur_par) * m_bt;
        wait_t(m_ts + cur_L / 2);
        chk(txd === 1'b1, "R3", txd, 1, "stop level");
        rx_q.push_back(m_b);
        t0_q.push_back(m_t0);
        ts_q.push_back(m_ts);
        rx_cnt++;
        mon_prev = 1'b1;
      end else begin
        mon_prev = (txd === 1'b1);
      end
    end
  end

  logic rts_prev = 1'b1;
  int rise_cnt = 0, rise_t = 0;
  always @(negedge clk) begin
    if (rtsn === 1'b1 && rts_prev !== 1'b1) begin
      rise_cnt++;
      rise_t = tcount;
    end
    rts_prev = rtsn;
  end

  // Drivers
  task automatic cmd(input bit on, input bit off, input bit ron, input bit roff);
    @(negedge clk);
    cmd_tx_on = on; cmd_tx_off = off; cmd_rts_on = ron; cmd_rts_off = roff;
    @(negedge clk);
    cmd_tx_on = 0; cmd_tx_off = 0; cmd_rts_on = 0; cmd_rts_off = 0;
  endtask

  task automatic set_mode(input int code, input bit gate, input bit autor,
                          input bit par, input bit x1);
    @(negedge clk);
    mode_we = 1'b1;
    mode_wdata = {x1, par, autor, gate, 4'(code)};
    @(negedge clk);
    mode_we = 1'b0;
    cur_par = par; cur_x1 = x1; cur_L = exp_stop(code, x1);
  endtask

  task automatic write_byte(input logic [7:0] b, input bit expect_ok);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
    if (expect_ok) exp_q.push_back(b);
  endtask

  task automatic wait_rx(input int n);
    while (rx_cnt < n) @(negedge clk);
  endtask

  int chk_idx = 0;
  task automatic check_data(input string req);
    chk(rx_cnt == exp_q.size(), req, rx_cnt, exp_q.size(), "frame count");
    for (int i = chk_idx; i < rx_cnt && i < exp_q.size(); i++)
      chk(rx_q[i] == exp_q[i], req, rx_q[i], exp_q[i], "frame byte");
    chk_idx = rx_cnt;
  endtask

  task automatic stop_group(input int code, input bit par);
    int base;
    base = rx_cnt;
    set_mode(code, 0, 0, par, 0);
    for (int i = 0; i < 3; i++) write_byte(8'($urandom), 1);
    wait_rx(base + 3);
    check_data("R1");
    for (int i = 0; i < 2; i++)
      chk(t0_q[base+i+1] - t0_q[base+i] == exp_frame(par, 0, code), "R3",
          t0_q[base+i+1] - t0_q[base+i], exp_frame(par, 0, code), "frame spacing");
    wait_ticks(40);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
    finish_run();
  end

  int base, snap, trel, code;
  bit par;

  initial begin
    void'($urandom(32'h5eed1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R12 reset state
    chk(txd === 1'b1, "R12", txd, 1, "txd after reset");
    chk(rtsn === 1'b1, "R12", rtsn, 1, "rtsn after reset");
    chk(tx_ready === 1'b0, "R12", tx_ready, 0, "tx_ready after reset");
    chk(fifo_full === 1'b0, "R12", fifo_full, 0, "fifo_full after reset");

    // R10 manual assertion, R8 ready when enabled
    cmd(1, 0, 1, 0);
    chk(rtsn === 1'b0, "R10", rtsn, 0, "rtsn after assert command");
    chk(tx_ready === 1'b1, "R8", tx_ready, 1, "tx_ready when enabled");

    // R3 directed stop codes at the range edges, then random ones
    stop_group(0, 0);
    stop_group(7, 1);
    stop_group(8, 0);
    stop_group(15, 1);
    for (int g = 0; g < 4; g++) begin
      code = $urandom_range(0, 15);
      par  = 1'($urandom_range(0, 1));
      stop_group(code, par);
    end
    chk(rtsn === 1'b0, "R10", rtsn, 0, "rtsn kept low after drain without auto mode");

    // R11 auto mode while enabled: no release
    set_mode(5, 0, 1, 0, 0);
    snap = rise_cnt;
    write_byte(8'hA5, 1);
    write_byte(8'h3C, 1);
    wait_rx(rx_cnt + 2);
    wait_ticks(60);
    chk(rise_cnt == snap, "R11", rise_cnt, snap, "no release while enabled");
    check_data("R1");

    // R9, R11 disable right after loading: queue drains, then exact release
    base = rx_cnt;
    write_byte(8'h81, 1);
    write_byte(8'h7E, 1);
    write_byte(8'h00, 1);
    cmd(0, 1, 0, 0);
    chk(tx_ready === 1'b0, "R8", tx_ready, 0, "tx_ready when disabled");
    wait_rx(base + 3);
    check_data("R9");
    wait_ticks(cur_L + 40);
    chk(rise_cnt == snap + 1, "R11", rise_cnt, snap + 1, "single auto release");
    chk(rise_t == ts_q[base+2] + cur_L + 16, "R11", rise_t,
        ts_q[base+2] + cur_L + 16, "release strobe");

    // R8 write while disabled is dropped
    base = rx_cnt;
    write_byte(8'h55, 0);
    wait_ticks(60);
    chk(rx_cnt == base, "R8", rx_cnt, base, "write while disabled dropped");

    // R5 gating holds a character
    cmd(1, 0, 1, 0);
    set_mode(0, 1, 0, 0, 0);
    ctsn = 1'b1;
    repeat (4) @(negedge clk);
    base = rx_cnt;
    write_byte(8'h96, 1);
    wait_ticks(60);
    chk(rx_cnt == base, "R5", rx_cnt, base, "held while ctsn high");
    chk(txd === 1'b1, "R5", txd, 1, "line marking while held");
    @(negedge clk);
    ctsn = 1'b0;
    trel = tcount;
    wait_rx(base + 1);
    chk(t0_q[base] - trel <= 2, "R5", t0_q[base] - trel, 2, "start soon after ctsn low");
    check_data("R5");

    // R6 ctsn change mid-character
    base = rx_cnt;
    write_byte(8'hC3, 1);
    write_byte(8'h1F, 1);
    while (txd !== 1'b0) @(negedge clk);
    wait_ticks(40);
    ctsn = 1'b1;
    wait_rx(base + 1);
    chk(rx_q[base] == 8'hC3, "R6", rx_q[base], 8'hC3, "character finished across ctsn change");
    chk_idx = base + 1;
    wait_ticks(120);
    chk(rx_cnt == base + 1, "R5", rx_cnt, base + 1, "next character waits for ctsn");
    ctsn = 1'b0;
    wait_rx(base + 2);
    check_data("R6");
    wait_ticks(30);

    // R7 gating off ignores ctsn
    set_mode(3, 0, 0, 1, 0);
    ctsn = 1'b1;
    repeat (4) @(negedge clk);
    base = rx_cnt;
    write_byte(8'h42, 1);
    wait_rx(base + 1);
    check_data("R7");
    wait_ticks(40);

    // R8 full queue drops extra writes
    set_mode(0, 1, 0, 0, 0);
    repeat (4) @(negedge clk);
    base = rx_cnt;
    for (int i = 0; i < DEPTH + 3; i++) write_byte(8'(8'h10 + i), i < DEPTH);
    chk(fifo_full === 1'b1, "R8", fifo_full, 1, "full after depth writes");
    chk(tx_ready === 1'b0, "R8", tx_ready, 0, "not ready when full");
    ctsn = 1'b0;
    wait_rx(base + DEPTH);
    wait_ticks(400);
    check_data("R8");

    // R4, R11 one strobe per bit with two stops and parity, auto release
    set_mode(1, 0, 1, 1, 1);
    snap = rise_cnt;
    cmd(0, 0, 1, 0);
    base = rx_cnt;
    write_byte(8'hE7, 1);
    write_byte(8'h18, 1);
    write_byte(8'h6B, 1);
    cmd(0, 1, 0, 0);
    wait_rx(base + 3);
    wait_ticks(10);
    check_data("R4");
    for (int i = 0; i < 2; i++)
      chk(t0_q[base+i+1] - t0_q[base+i] == exp_frame(1, 1, 1), "R4",
          t0_q[base+i+1] - t0_q[base+i], exp_frame(1, 1, 1), "1x spacing");
    chk(rise_t == ts_q[base+2] + 2 + 1, "R11", rise_t, ts_q[base+2] + 3,
        "1x release strobe");
    chk(rise_cnt == snap + 1, "R11", rise_cnt, snap + 1, "1x single release");

    // R4 single stop in 1x mode
    cmd(1, 0, 0, 0);
    set_mode(0, 0, 0, 0, 1);
    base = rx_cnt;
    write_byte(8'h99, 1);
    write_byte(8'h01, 1);
    wait_rx(base + 2);
    check_data("R4");
    chk(t0_q[base+1] - t0_q[base] == exp_frame(0, 1, 0), "R4",
        t0_q[base+1] - t0_q[base], exp_frame(0, 1, 0), "1x one stop spacing");
    wait_ticks(10);

    // R10 manual negation
    cmd(0, 0, 1, 0);
    cmd(0, 0, 0, 1);
    chk(rtsn === 1'b1, "R10", rtsn, 1, "rtsn after negate command");

    finish_run();
  end

endmodule